// File: doc/BRIEF.md
# Triggered Hit End-of-Column Buffer

This block sits at the bottom of a pixel column. It receives hits one per clock. Each hit carries a row address, a column address and a time-over-threshold value. The block stamps every hit with a 7-bit crossing number. That number advances once every `BC_DIV` clocks and wraps after 127. Hits wait in a 16-slot store until the trigger decision for their crossing is known.

A trigger pulse seen during crossing C asks for the hits of crossing C − L, where L is the programmed trigger latency (1 to 127 crossings). The block marks those hits as wanted and queues the crossing number in a 4-entry trigger queue. Hits that no trigger asked for are released when their age passes L, which frees their slots.

A serialiser pops one queued crossing at a time. It sends that crossing's hits as one frame, one bit per clock, most significant bit first. A sticky overflow flag records a hit lost because the store was full, or a trigger lost because the queue was full. The flag travels in the next frame header and is then cleared.

The serialiser is a four-state machine:
- IDLE → HEAD when the queue is not empty (the pop).
- HEAD → HITS at the end of the header if a wanted hit of the event crossing is stored; HEAD → TAIL otherwise.
- HITS → HITS at the end of a hit word if another such hit is stored; HITS → TAIL otherwise.
- TAIL → IDLE at the end of the trailer.

Top module: `eoc_trigger_buffer`

## Requirements
- R1: While `rst_n` is low and right after reset, `ser_frame` and `ser_out` are 0 and `cur_crossing` is 0.
- R2: `cur_crossing` advances by exactly one every `BC_DIV` (default 4) clocks, modulo 128. A hit is tagged with the `cur_crossing` value present in the clock that captures it.
- R3: A trigger captured while `cur_crossing` is C produces one frame whose header crossing is (C − `trig_latency`) mod 128. That frame carries the stored hits tagged with that crossing.
- R4: Frame layout, MSB first, with `ser_frame` high for exactly its bits:
  - a start bit 1;
  - the 7-bit crossing;
  - the overflow bit;
  - for each hit, a 1 followed by row[3:0], col[2:0] and tot[3:0];
  - the trailer 0101.
  Outside frames `ser_out` is 0.
- R5: All selected hits of one crossing leave in one frame, in storage-slot order. When the store starts empty, that is arrival order.
- R6: A hit that no trigger selected never appears in a frame. It is released once its age exceeds `trig_latency` crossings, and its slot can then hold a new hit.
- R7: The store holds 16 hits. A hit arriving while all 16 slots are occupied is dropped and sets the overflow flag.
- R8: The trigger queue holds 4 crossings. A trigger arriving while 4 are pending is dropped and sets the overflow flag.
- R9: The overflow flag is copied into the header of the next frame to start. It is then cleared, unless a new overflow occurs in that same clock.
- R10: With the serialiser idle and the queue empty, the start bit is on `ser_out` in the clock that follows the edge capturing the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A hit is presented this clock |
| hit_row | input | 4 | Row address of the hit |
| hit_col | input | 3 | Column address of the hit |
| hit_tot | input | 4 | Time-over-threshold value of the hit |
| trig | input | 1 | Trigger pulse, at most one per crossing |
| trig_latency | input | 7 | Trigger latency in crossings, 1 to 127, held static |
| cur_crossing | output | 7 | Current crossing number |
| ser_out | output | 1 | Serial event data |
| ser_frame | output | 1 | High while a frame bit is on `ser_out` |

## Verification
A hit is tagged at the edge that captures it. The testbench drives hits on falling edges right after it sees `cur_crossing` change, so all of them land in that crossing. A trigger shows `ser_frame` high at the second falling edge after it is driven. The testbench checks this through a clock counter that moves only on rising edges.

Overflow is set one edge after the loss and is reported at the next pop. In the queue test, triggers arrive every four clocks and each empty frame plus its idle gap takes fourteen clocks. Working through that timing shows the third frame must carry the flag, and that exactly six frames must appear. Every frame is recorded by a falling-edge monitor and decoded afterwards.

// File: rtl/eoc_pkg.sv
package eoc_pkg;
    parameter int ROW_W = 4;
    parameter int COL_W = 3;
    parameter int TOT_W = 4;
    parameter int BC_W  = 7;
    localparam int HIT_W = ROW_W + COL_W + TOT_W;
    localparam int SH_W  = HIT_W + 1;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [TOT_W-1:0] tot;
    } hit_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HEAD = 2'd1,
        S_HITS = 2'd2,
        S_TAIL = 2'd3
    } ser_state_t;

    localparam logic [3:0] TRAILER = 4'b0101;
endpackage

// File: rtl/eoc_hit_store.sv
module eoc_hit_store
    import eoc_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [BC_W-1:0] bc_now,
    input  logic [BC_W-1:0] lat,
    input  logic            wr_en,
    input  hit_t            wr_data,
    input  logic            mark_en,
    input  logic [BC_W-1:0] mark_bc,
    input  logic [BC_W-1:0] sel_bc,
    input  logic            sel_take,
    output logic            full,
    output logic            sel_found,
    output hit_t            sel_word
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int AGE_W = BC_W + 1;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [DEPTH-1:0] valid;
    logic [DEPTH-1:0] kept;
    logic [BC_W-1:0]  tag  [DEPTH];
    logic [AGE_W-1:0] age  [DEPTH];
    hit_t             data [DEPTH];

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] sel_idx;

    // lowest free slot and lowest wanted hit of the event crossing
    always_comb begin
        wr_idx    = '0;
        sel_idx   = '0;
        sel_found = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid[i]) wr_idx = IDX_W'(i);
            if (valid[i] && kept[i] && tag[i] == sel_bc) begin
                sel_idx   = IDX_W'(i);
                sel_found = 1'b1;
            end
        end
    end

    assign full     = &valid;
    assign sel_word = data[sel_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            kept  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (valid[i]) begin
                    if (sel_take && sel_found && sel_idx == IDX_W'(i)) begin
                        valid[i] <= 1'b0;
                    end else if (!kept[i] && age[i] > {1'b0, lat}) begin
                        valid[i] <= 1'b0;
                    end else begin
                        if (mark_en && tag[i] == mark_bc) kept[i] <= 1'b1;
                        if (tick && age[i] != AGE_MAX) age[i] <= age[i] + 1'b1;
                    end
                end else if (wr_en && !full && wr_idx == IDX_W'(i)) begin
                    valid[i] <= 1'b1;
                    kept[i]  <= 1'b0;
                    tag[i]   <= bc_now;
                    age[i]   <= tick ? AGE_W'(1) : '0;
                    data[i]  <= wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/eoc_trig_fifo.sv
module eoc_trig_fifo
    import eoc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [BC_W-1:0] din,
    input  logic            pop,
    output logic [BC_W-1:0] dout,
    output logic            empty,
    output logic            full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [BC_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/eoc_serializer.sv
module eoc_serializer
    import eoc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            q_empty,
    input  logic [BC_W-1:0] q_data,
    input  logic            ovf_flag,
    input  logic            sel_found,
    input  hit_t            sel_word,
    output logic            q_pop,
    output logic            sel_take,
    output logic [BC_W-1:0] sel_bc,
    output logic            ser_out,
    output logic            ser_frame
);
    localparam int CNT_W = $clog2(SH_W);
    localparam int HDR_BITS = 1 + BC_W + 1;

    ser_state_t       state, state_nx;
    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] cnt;
    logic [BC_W-1:0]  ev_bc;
    logic             seg_end;

    // state register and shift datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            sh    <= '0;
            cnt   <= '0;
            ev_bc <= '0;
        end else begin
            state <= state_nx;
            if (q_pop) begin
                ev_bc <= q_data;
                sh    <= {1'b1, q_data, ovf_flag, {(SH_W - HDR_BITS){1'b0}}};
                cnt   <= CNT_W'(HDR_BITS - 1);
            end else if (seg_end && state != S_TAIL) begin
                if (sel_found) begin
                    sh  <= {1'b1, sel_word};
                    cnt <= CNT_W'(SH_W - 1);
                end else begin
                    sh  <= {TRAILER, {(SH_W - 4){1'b0}}};
                    cnt <= CNT_W'(3);
                end
            end else if (state != S_IDLE) begin
                sh  <= sh << 1;
                cnt <= cnt - 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        q_pop     = 1'b0;
        sel_take  = 1'b0;
        seg_end   = (cnt == '0);
        state_nx  = state;
        unique case (state)
            S_IDLE: begin
                seg_end = 1'b0;
                if (!q_empty) begin
                    q_pop    = 1'b1;
                    state_nx = S_HEAD;
                end
            end
            S_HEAD, S_HITS: begin
                if (seg_end) begin
                    sel_take = sel_found;
                    state_nx = sel_found ? S_HITS : S_TAIL;
                end
            end
            S_TAIL: begin
                if (seg_end) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    assign sel_bc    = ev_bc;
    assign ser_frame = (state != S_IDLE);
    assign ser_out   = ser_frame & sh[SH_W-1];
endmodule

// File: rtl/eoc_trigger_buffer.sv
module eoc_trigger_buffer
    import eoc_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int TQ_DEPTH = 4,
    parameter int BC_DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid,
    input  logic [ROW_W-1:0] hit_row,
    input  logic [COL_W-1:0] hit_col,
    input  logic [TOT_W-1:0] hit_tot,
    input  logic             trig,
    input  logic [BC_W-1:0]  trig_latency,
    output logic [BC_W-1:0]  cur_crossing,
    output logic             ser_out,
    output logic             ser_frame
);
    localparam int PRE_W = (BC_DIV > 1) ? $clog2(BC_DIV) : 1;

    logic [PRE_W-1:0] pre;
    logic [BC_W-1:0]  bc;
    logic             tick;
    logic [BC_W-1:0]  trig_bc;
    logic             buf_full, q_full, q_empty, q_pop, q_push;
    logic [BC_W-1:0]  q_data;
    logic             ovf_flag, ovf_set;
    logic             sel_found, sel_take;
    logic [BC_W-1:0]  sel_bc;
    hit_t             sel_word, wr_data;

    assign tick    = (pre == PRE_W'(BC_DIV - 1));
    assign trig_bc = bc - trig_latency;
    assign q_push  = trig && !q_full;
    assign ovf_set = (hit_valid && buf_full) || (trig && q_full);
    assign wr_data = '{row: hit_row, col: hit_col, tot: hit_tot};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre      <= '0;
            bc       <= '0;
            ovf_flag <= 1'b0;
        end else begin
            pre      <= tick ? '0 : pre + 1'b1;
            if (tick) bc <= bc + 1'b1;
            ovf_flag <= ovf_set | (ovf_flag & ~q_pop);
        end
    end

    eoc_hit_store #(.DEPTH(DEPTH)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bc_now    (bc),
        .lat       (trig_latency),
        .wr_en     (hit_valid),
        .wr_data   (wr_data),
        .mark_en   (q_push),
        .mark_bc   (trig_bc),
        .sel_bc    (sel_bc),
        .sel_take  (sel_take),
        .full      (buf_full),
        .sel_found (sel_found),
        .sel_word  (sel_word)
    );

    eoc_trig_fifo #(.DEPTH(TQ_DEPTH)) i_tq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   (trig_bc),
        .pop   (q_pop),
        .dout  (q_data),
        .empty (q_empty),
        .full  (q_full)
    );

    eoc_serializer i_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_empty   (q_empty),
        .q_data    (q_data),
        .ovf_flag  (ovf_flag),
        .sel_found (sel_found),
        .sel_word  (sel_word),
        .q_pop     (q_pop),
        .sel_take  (sel_take),
        .sel_bc    (sel_bc),
        .ser_out   (ser_out),
        .ser_frame (ser_frame)
    );

    assign cur_crossing = bc;
endmodule

// File: rtl/eoc_trigger_buffer_chk.sv
module eoc_trigger_buffer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hit_valid,
    input logic       trig,
    input logic [6:0] cur_crossing,
    input logic       ser_out,
    input logic       ser_frame,
    input logic       buf_full,
    input logic       q_full,
    input logic       q_pop,
    input logic       ovf_set,
    input logic       ovf_flag
);
    // R2: crossing moves only by one step
    p_xing_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_crossing != $past(cur_crossing)) |-> (cur_crossing == 7'($past(cur_crossing) + 7'd1)));

    // R4: line quiet outside frames, frame opens with the start bit
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_frame |-> !ser_out);
    p_start_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_frame) |-> ser_out);

    // R7: hit lost on a full store raises overflow
    p_hit_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && buf_full) |=> ovf_flag);

    // R8: trigger lost on a full queue raises overflow
    p_trig_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && q_full) |=> ovf_flag);

    // R9: flag cleared by the header snapshot, held otherwise
    p_ovf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop && !ovf_set) |=> !ovf_flag);
    p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !q_pop) |=> ovf_flag);

    // R10: a pop starts a frame on the next cycle
    p_frame_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> (ser_frame && ser_out));
endmodule

bind eoc_trigger_buffer eoc_trigger_buffer_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_valid    (hit_valid),
    .trig         (trig),
    .cur_crossing (cur_crossing),
    .ser_out      (ser_out),
    .ser_frame    (ser_frame),
    .buf_full     (buf_full),
    .q_full       (q_full),
    .q_pop        (q_pop),
    .ovf_set      (ovf_set),
    .ovf_flag     (ovf_flag)
);

// File: tb/test_eoc_trigger_buffer.sv
module test_eoc_trigger_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_valid = 1'b0;
    logic [3:0] hit_row = '0;
    logic [2:0] hit_col = '0;
    logic [3:0] hit_tot = '0;
    logic       trig = 1'b0;
    logic [6:0] trig_latency = 7'd5;
    logic [6:0] cur_crossing;
    logic       ser_out, ser_frame;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    eoc_trigger_buffer i_eoc_trigger_buffer (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_row(hit_row),
        .hit_col(hit_col), .hit_tot(hit_tot), .trig(trig),
        .trig_latency(trig_latency), .cur_crossing(cur_crossing),
        .ser_out(ser_out), .ser_frame(ser_frame)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // frame monitor
    bit         fb [512];
    int         flen = 0;
    bit         in_fr = 1'b0;
    int         fr_n = 0;
    int         fr_bc [32];
    int         fr_ovf [32];
    int         fr_nh [32];
    int         fr_ok [32];
    int         fr_st [32];
    int         fr_w [32][16];
    int         cur_st = 0;

    always @(negedge clk) begin
        if (ser_frame) begin
            if (!in_fr) begin flen = 0; cur_st = cyc; end
            in_fr = 1'b1;
            if (flen < 512) fb[flen] = ser_out;
            flen++;
        end else if (in_fr) begin
            int p, v, nh, ok;
            in_fr = 1'b0;
            ok = (fb[0] == 1'b1);
            v = 0;
            for (int b = 1; b <= 7; b++) v = v * 2 + int'(fb[b]);
            fr_bc[fr_n] = v;
            fr_ovf[fr_n] = int'(fb[8]);
            p = 9; nh = 0;
            while (p < flen) begin
                if (fb[p] && p + 12 <= flen) begin
                    v = 0;
                    for (int b = 1; b <= 11; b++) v = v * 2 + int'(fb[p + b]);
                    if (nh < 16) fr_w[fr_n][nh] = v;
                    nh++; p += 12;
                end else begin
                    if (!(p + 4 == flen && !fb[p] && fb[p+1] && !fb[p+2] && fb[p+3])) ok = 0;
                    p = flen + 1;
                end
            end
            if (p == flen) ok = 0;
            fr_nh[fr_n] = nh; fr_ok[fr_n] = ok; fr_st[fr_n] = cur_st;
            if (fr_n < 31) fr_n++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int word(input int r, input int c, input int t);
        return (r << 7) | (c << 4) | t;
    endfunction

    task automatic wait_xing_start();
        logic [6:0] s;
        s = cur_crossing;
        do @(negedge clk); while (cur_crossing == s);
    endtask

    task automatic wait_xing(input logic [6:0] x);
        while (cur_crossing != x) @(negedge clk);
    endtask

    task automatic send_hit(input int r, input int c, input int t);
        hit_row = 4'(r); hit_col = 3'(c); hit_tot = 4'(t);
        hit_valid = 1'b1;
        @(negedge clk);
        hit_valid = 1'b0;
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        while (fr_n < n) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 frame in reset", int'(ser_frame), 0);
        chk("R1 out in reset", int'(ser_out), 0);
        chk("R1 crossing in reset", int'(cur_crossing), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 crossing after reset", int'(cur_crossing), 0);
        chk("R1 frame after reset", int'(ser_frame), 0);
        wait_xing_start();
        chk("R2 first step", int'(cur_crossing), 1);
        repeat (4) @(negedge clk);
        chk("R2 step after BC_DIV clocks", int'(cur_crossing), 2);
    endtask

    task automatic t_single();
        logic [6:0] h;
        int k, base;
        trig_latency = 7'd5;
        base = fr_n;
        wait_xing_start();
        h = cur_crossing;
        send_hit(3, 5, 9);
        wait_xing(7'(h + 7'd5));
        k = cyc;
        pulse_trig();
        wait_frames(base + 1);
        chk("R10 start cycle", fr_st[base], k + 2);
        chk("R4 framing", fr_ok[base], 1);
        chk("R3 header crossing", fr_bc[base], int'(h));
        chk("R9 ovf clear", fr_ovf[base], 0);
        chk("R3 hit count", fr_nh[base], 1);
        chk("R4 hit word", fr_w[base][0], word(3, 5, 9));
    endtask

    task automatic t_group();
        logic [6:0] h;
        int base;
        trig_latency = 7'd6;
        base = fr_n;
        wait_xing_start();
        h = cur_crossing;
        send_hit(1, 2, 3);
        send_hit(15, 7, 15);
        send_hit(8, 0, 4);
        wait_xing_start();
        send_hit(6, 6, 6);
        wait_xing(7'(h + 7'd6));
        pulse_trig();
        wait_frames(base + 1);
        chk("R4 group framing", fr_ok[base], 1);
        chk("R5 group crossing", fr_bc[base], int'(h));
        chk("R5 group count", fr_nh[base], 3);
        chk("R5 order 0", fr_w[base][0], word(1, 2, 3));
        chk("R5 order 1", fr_w[base][1], word(15, 7, 15));
        chk("R5 order 2", fr_w[base][2], word(8, 0, 4));
    endtask

    task automatic t_age();
        logic [6:0] h, ht;
        int base;
        trig_latency = 7'd3;
        repeat (60) @(negedge clk);
        base = fr_n;
        wait_xing_start();
        h = cur_crossing;
        for (int c = 0; c < 4; c++) begin
            if (c != 0) wait_xing_start();
            for (int j = 0; j < 4; j++) send_hit(c, j, 1);
        end
        wait_xing(7'(h + 7'd9));
        wait_xing_start();
        ht = cur_crossing;
        send_hit(9, 3, 12);
        wait_xing(7'(ht + 7'd3));
        pulse_trig();
        wait_frames(base + 1);
        chk("R6 freed slot frame", fr_ok[base], 1);
        chk("R6 no overflow after release", fr_ovf[base], 0);
        chk("R6 only new hit", fr_nh[base], 1);
        chk("R6 new hit word", fr_w[base][0], word(9, 3, 12));
    endtask

    task automatic t_hit_ovf();
        logic [6:0] h1, h5;
        int base;
        trig_latency = 7'd10;
        repeat (60) @(negedge clk);
        base = fr_n;
        wait_xing_start();
        h1 = cur_crossing;
        for (int c = 0; c < 4; c++) begin
            if (c != 0) wait_xing_start();
            for (int j = 0; j < 4; j++) send_hit(j, c, c + 4);
        end
        wait_xing_start();
        h5 = cur_crossing;
        send_hit(10, 1, 2);
        wait_xing(7'(h1 + 7'd10));
        pulse_trig();
        wait_xing(7'(h5 + 7'd10));
        pulse_trig();
        wait_frames(base + 2);
        chk("R7 full frame ovf", fr_ovf[base], 1);
        chk("R7 first crossing hits", fr_nh[base], 4);
        chk("R5 full order", fr_w[base][3], word(3, 0, 4));
        chk("R9 ovf cleared next frame", fr_ovf[base + 1], 0);
        chk("R7 dropped hit absent", fr_nh[base + 1], 0);
        chk("R3 second crossing", fr_bc[base + 1], int'(h5));
    endtask

    task automatic t_trig_ovf();
        int base;
        int xb [8];
        trig_latency = 7'd20;
        repeat (200) @(negedge clk);
        base = fr_n;
        for (int k = 0; k < 8; k++) begin
            xb[k] = int'(7'(cur_crossing - 7'd20));
            pulse_trig();
            repeat (3) @(negedge clk);
        end
        repeat (120) @(negedge clk);
        chk("R8 frame count", fr_n - base, 6);
        for (int k = 0; k < 6; k++) begin
            chk("R8 queued crossing", fr_bc[base + k], xb[k]);
            chk("R9 ovf position", fr_ovf[base + k], (k == 2) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_group();
        t_age();
        t_hit_ovf();
        t_trig_ovf();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule